// File: doc/BRIEF.md
# Status Register and Write Permission Unit

This block keeps the status byte of a serial nonvolatile memory and rules on every write the command decoder wants to commit. The byte carries a lock-enable bit for the write-protect pin, a three-bit lock code that selects a protected address range, the write enable latch and the busy flag. The block takes the write-protect pin level and single-cycle events from the decoder: enable-latch set, enable-latch clear, status-write frame open, status-write commit, array-write frame open, and array-write commit. For each array write it also takes a stream of per-byte target addresses.

Each commit is answered one cycle later by exactly one grant or deny pulse. A granted write starts a fixed busy period. When that period ends, the enable latch clears, and a granted status write copies its new lock fields into the register. The lock-enable and lock-code bits are plain registers that clear at reset.

The address stream is valid/ready. A beat transfers on a clock edge where `pg_addr_valid_i` and `pg_addr_ready_o` are both high. `pg_addr_ready_o` is low for the whole busy period. A beat offered while ready is low is not taken, and the producer keeps it until ready returns. All other pins are plain levels or one-cycle pulses.

Top module: `prot_status_unit`

## Requirements
- R1: The status byte `status_o` is laid out as follows when idle: bit 7 is the lock-enable bit, bits 6 and 5 read 0, bits 4..2 hold the lock code, bit 1 is the enable latch and bit 0 is the busy flag. After reset the byte is 0x00.
- R2: A `wren_i` pulse sets the enable latch and a `wrdi_i` pulse clears it. While busy, both pulses are ignored.
- R3: While a write is busy, `status_o` reads 0xFF.
- R4: Lock code to protected range, with AW=15 and 64-byte pages. 000 protects nothing. 001 protects 0x6000..0x7FFF. 010 protects 0x4000..0x7FFF. 011 protects every address. 100 protects 0x000..0x03F. 101 protects 0x000..0x07F. 110 protects 0x000..0x0FF. 111 protects 0x000..0x1FF.
- R5: An array commit is granted only when all of these hold: the enable latch is 1, the block is not busy, at least one beat arrived since `arr_open_i`, and no beat hit a protected address. Otherwise it is denied. The grant or deny pulse is high for one cycle, in the cycle after the commit.
- R6: If any beat of a multi-byte write hits a protected address, the whole write is denied. A deny leaves the enable latch set.
- R7: A grant keeps the busy flag high for exactly BUSY_CYCLES cycles. When the busy period ends, the enable latch clears.
- R8: Hardware protection is active when the pin is low and the lock-enable bit is 1. While it is active, a status commit is denied. Otherwise a status commit follows the same enable-latch and busy rules as R5. Data bits 6, 5, 1 and 0 of a status write are ignored. The new lock-enable and lock-code bits appear only after the busy period.
- R9: A status frame is denied if hardware protection was active at any cycle between its open and its commit, even when it is inactive at commit. Once a status write has been granted, the pin level has no effect on it.
- R10: `pg_addr_ready_o` is low while busy. While the lock-enable bit is 0, the pin level has no effect on status writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n_i | input | 1 | Write-protect pin level (low = protect request) |
| wren_i | input | 1 | Pulse: set enable latch |
| wrdi_i | input | 1 | Pulse: clear enable latch |
| wrsr_open_i | input | 1 | Pulse: status-write frame begins |
| wrsr_commit_i | input | 1 | Pulse: status-write frame ends validly |
| wrsr_data_i | input | 8 | Status-write data byte, valid with commit |
| arr_open_i | input | 1 | Pulse: array-write frame begins |
| pg_addr_valid_i | input | 1 | Byte address beat valid |
| pg_addr_ready_o | output | 1 | Byte address beat accepted |
| pg_addr_i | input | AW | Target address of one byte |
| arr_commit_i | input | 1 | Pulse: array-write frame ends validly |
| arr_grant_o | output | 1 | Array write granted (one cycle) |
| arr_deny_o | output | 1 | Array write refused (one cycle) |
| sr_grant_o | output | 1 | Status write granted (one cycle) |
| sr_deny_o | output | 1 | Status write refused (one cycle) |
| status_o | output | 8 | Status byte as read by the host |

## Verification
The bench builds the block with AW=15 and PAGE_BYTES=64, so every range boundary in the lock-code table falls on a real address. With these values, each of the eight codes can be swept against fourteen edge addresses. BUSY_CYCLES is set to 12, which keeps each busy period short enough for well over a hundred granted writes. It is still long enough to issue competing commits, latch pulses and pin changes inside one busy period.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int SR_W      = 8;
  localparam int SR_LOCKEN = 7;
  localparam int SR_CODE   = 2;
  localparam int SR_WEL    = 1;
  localparam int SR_BUSY   = 0;

  typedef logic [2:0] lock_code_t;

  // Host-visible status byte; saturates to all ones while busy.
  function automatic logic [SR_W-1:0] pack_status(input logic locken,
                                                  input lock_code_t code,
                                                  input logic wel,
                                                  input logic busy);
    logic [SR_W-1:0] b;
    b = '0;
    b[SR_LOCKEN] = locken;
    b[SR_CODE +: 3] = code;
    b[SR_WEL] = wel;
    if (busy) b = '1;
    return b;
  endfunction
endpackage

// File: rtl/prot_range_map.sv
module prot_range_map
  import prot_pkg::*;
#(
  parameter int AW         = 15,
  parameter int PAGE_BYTES = 64
) (
  input  lock_code_t       code_i,
  input  logic [AW-1:0]    addr_i,
  output logic             hit_o
);
  localparam logic [AW-1:0] PAGE_SZ = AW'(PAGE_BYTES);

  logic [AW-1:0] low_lim;

  always_comb begin
    low_lim = PAGE_SZ << code_i[1:0];
    unique case (code_i)
      3'b000:  hit_o = 1'b0;
      3'b001:  hit_o = &addr_i[AW-1 -: 2];
      3'b010:  hit_o = addr_i[AW-1];
      3'b011:  hit_o = 1'b1;
      default: hit_o = addr_i < low_lim;
    endcase
  end
endmodule

// File: rtl/wr_span_gate.sv
module wr_span_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic close_i,
  input  logic beat_i,
  input  logic beat_hit_i,
  output logic any_hit_o,
  output logic any_beat_o
);
  logic hit_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (open_i || close_i) begin
      hit_q  <= 1'b0;
      seen_q <= 1'b0;
    end else if (beat_i) begin
      hit_q  <= hit_q | beat_hit_i;
      seen_q <= 1'b1;
    end
  end

  assign any_hit_o  = hit_q | (beat_i & beat_hit_i);
  assign any_beat_o = seen_q | beat_i;
endmodule

// File: rtl/wr_busy_timer.sv
module wr_busy_timer #(
  parameter int CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/prot_status_unit.sv
module prot_status_unit
  import prot_pkg::*;
#(
  parameter int AW          = 15,
  parameter int PAGE_BYTES  = 64,
  parameter int BUSY_CYCLES = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n_i,
  input  logic          wren_i,
  input  logic          wrdi_i,
  input  logic          wrsr_open_i,
  input  logic          wrsr_commit_i,
  input  logic [7:0]    wrsr_data_i,
  input  logic          arr_open_i,
  input  logic          pg_addr_valid_i,
  output logic          pg_addr_ready_o,
  input  logic [AW-1:0] pg_addr_i,
  input  logic          arr_commit_i,
  output logic          arr_grant_o,
  output logic          arr_deny_o,
  output logic          sr_grant_o,
  output logic          sr_deny_o,
  output logic [7:0]    status_o
);
  logic       locken_q, wel_q;
  lock_code_t code_q;
  logic       pend_locken_q, pend_sr_q;
  lock_code_t pend_code_q;
  logic       frame_q, wp_seen_q;

  logic busy, done, hw_prot;
  logic beat, beat_hit, any_hit, any_beat;
  logic arr_ok, sr_ok;

  assign hw_prot         = ~wp_n_i & locken_q;
  assign pg_addr_ready_o = ~busy;
  assign beat            = pg_addr_valid_i & pg_addr_ready_o;

  prot_range_map #(.AW(AW), .PAGE_BYTES(PAGE_BYTES)) map_i (
    .code_i (code_q),
    .addr_i (pg_addr_i),
    .hit_o  (beat_hit)
  );

  wr_span_gate span_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (arr_open_i),
    .close_i    (arr_commit_i),
    .beat_i     (beat),
    .beat_hit_i (beat_hit),
    .any_hit_o  (any_hit),
    .any_beat_o (any_beat)
  );

  assign arr_ok = arr_commit_i & wel_q & ~busy & any_beat & ~any_hit;
  assign sr_ok  = wrsr_commit_i & ~arr_commit_i & wel_q & ~busy &
                  ~hw_prot & ~wp_seen_q;

  wr_busy_timer #(.CYCLES(BUSY_CYCLES)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (arr_ok | sr_ok),
    .busy_o  (busy),
    .done_o  (done)
  );

  // Status frame tracking: a protect request seen mid-frame poisons it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q   <= 1'b0;
      wp_seen_q <= 1'b0;
    end else if (wrsr_open_i) begin
      frame_q   <= 1'b1;
      wp_seen_q <= 1'b0;
    end else if (wrsr_commit_i) begin
      frame_q   <= 1'b0;
      wp_seen_q <= 1'b0;
    end else if (frame_q && hw_prot) begin
      wp_seen_q <= 1'b1;
    end
  end

  // Enable latch and lock fields.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q         <= 1'b0;
      locken_q      <= 1'b0;
      code_q        <= '0;
      pend_sr_q     <= 1'b0;
      pend_locken_q <= 1'b0;
      pend_code_q   <= '0;
    end else begin
      if (done)                wel_q <= 1'b0;
      else if (!busy && wren_i) wel_q <= 1'b1;
      else if (!busy && wrdi_i) wel_q <= 1'b0;

      if (sr_ok) begin
        pend_sr_q     <= 1'b1;
        pend_locken_q <= wrsr_data_i[SR_LOCKEN];
        pend_code_q   <= wrsr_data_i[SR_CODE +: 3];
      end else if (done) begin
        pend_sr_q <= 1'b0;
        if (pend_sr_q) begin
          locken_q <= pend_locken_q;
          code_q   <= pend_code_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_grant_o <= 1'b0;
      arr_deny_o  <= 1'b0;
      sr_grant_o  <= 1'b0;
      sr_deny_o   <= 1'b0;
    end else begin
      arr_grant_o <= arr_ok;
      arr_deny_o  <= arr_commit_i & ~arr_ok;
      sr_grant_o  <= sr_ok;
      sr_deny_o   <= wrsr_commit_i & ~sr_ok;
    end
  end

  assign status_o = pack_status(locken_q, code_q, wel_q, busy);
endmodule

// File: rtl/prot_status_checker.sv
module prot_status_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n_i,
  input logic       wrsr_commit_i,
  input logic       arr_commit_i,
  input logic       pg_addr_ready_o,
  input logic       arr_grant_o,
  input logic       arr_deny_o,
  input logic       sr_grant_o,
  input logic       sr_deny_o,
  input logic [7:0] status_o
);
  // R5: one verdict per commit, never both
  assert_one_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_grant_o && arr_deny_o) && !(sr_grant_o && sr_deny_o));

  // R5: grant needs latch set and idle in the commit cycle
  assert_grant_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant_o |-> ($past(status_o[1]) && !$past(status_o[0])));

  // R8: no status grant while hardware protection was active
  assert_hw_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant_o |-> ($past(wp_n_i) || !$past(status_o[7])));

  // R7: busy begins only after a commit
  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[0]) |-> $past(arr_commit_i || wrsr_commit_i));

  // R10: no beats accepted while busy
  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> !pg_addr_ready_o);
endmodule

bind prot_status_unit prot_status_checker chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .wp_n_i          (wp_n_i),
  .wrsr_commit_i   (wrsr_commit_i),
  .arr_commit_i    (arr_commit_i),
  .pg_addr_ready_o (pg_addr_ready_o),
  .arr_grant_o     (arr_grant_o),
  .arr_deny_o      (arr_deny_o),
  .sr_grant_o      (sr_grant_o),
  .sr_deny_o       (sr_deny_o),
  .status_o        (status_o)
);

// File: tb/prot_status_unit_tb_top.sv
`timescale 1ns/1ps
module prot_status_unit_tb_top;
  localparam int AW   = 15;
  localparam int BUSY = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0;
  logic wrsr_open = 1'b0, wrsr_commit = 1'b0;
  logic [7:0] wrsr_data = '0;
  logic arr_open = 1'b0, pg_valid = 1'b0, arr_commit = 1'b0;
  logic [AW-1:0] pg_addr = '0;
  logic pg_ready, arr_grant, arr_deny, sr_grant, sr_deny;
  logic [7:0] status;

  int checks = 0, errors = 0;
  logic [1:0] exp_q[$];       // {is_status, granted}
  logic [AW-1:0] beats[$];

  always #4 clk = ~clk;

  prot_status_unit #(.AW(AW), .PAGE_BYTES(64), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_open_i(wrsr_open), .wrsr_commit_i(wrsr_commit), .wrsr_data_i(wrsr_data),
    .arr_open_i(arr_open), .pg_addr_valid_i(pg_valid), .pg_addr_ready_o(pg_ready),
    .pg_addr_i(pg_addr), .arr_commit_i(arr_commit), .arr_grant_o(arr_grant),
    .arr_deny_o(arr_deny), .sr_grant_o(sr_grant), .sr_deny_o(sr_deny),
    .status_o(status));

  // Monitor: pops expected verdicts as the design produces them
  always @(negedge clk) begin
    if (rst_n && (arr_grant || arr_deny || sr_grant || sr_deny)) begin
      logic [1:0] got, exp;
      got = {sr_grant | sr_deny, arr_grant | sr_grant};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected verdict got=%b expected=none", got);
      end else begin
        exp = exp_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL R5/R8 verdict got=%b expected=%b", got, exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog got=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit prot_model(input logic [2:0] c, input logic [AW-1:0] a);
    case (c)
      3'd0: return 1'b0;
      3'd1: return a >= 15'h6000;
      3'd2: return a >= 15'h4000;
      3'd3: return 1'b1;
      3'd4: return a <= 15'h003F;
      3'd5: return a <= 15'h007F;
      3'd6: return a <= 15'h00FF;
      default: return a <= 15'h01FF;
    endcase
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic do_wren(); wren = 1'b1; step(); wren = 1'b0; step(); endtask
  task automatic do_wrdi(); wrdi = 1'b1; step(); wrdi = 1'b0; step(); endtask

  task automatic arr_write(input bit exp_grant);
    arr_open = 1'b1; step(); arr_open = 1'b0;
    while (beats.size() > 0) begin
      pg_valid = 1'b1; pg_addr = beats.pop_front(); step();
    end
    pg_valid = 1'b0;
    exp_q.push_back({1'b0, exp_grant});
    arr_commit = 1'b1; step(); arr_commit = 1'b0; step();
  endtask

  task automatic sr_write(input logic [7:0] d, input bit exp_grant);
    wrsr_open = 1'b1; step(); wrsr_open = 1'b0; step();
    wrsr_data = d;
    exp_q.push_back({1'b1, exp_grant});
    wrsr_commit = 1'b1; step(); wrsr_commit = 1'b0; step();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status == 8'hFF && n < 1000) begin n++; step(); end
  endtask

  initial begin
    int n;
    repeat (3) step();
    rst_n = 1'b1; step();
    chk("R1 reset status", status, 8'h00);
    chk("R10 ready idle", pg_ready, 1'b1);

    // R5: no enable latch -> deny
    beats.push_back(15'h0100); arr_write(1'b0);
    chk("R5 deny keeps status", status, 8'h00);

    // R2
    do_wren(); chk("R2 wren sets latch", status, 8'h02);
    do_wrdi(); chk("R2 wrdi clears latch", status, 8'h00);
    do_wren();

    // R5: empty frame -> deny
    arr_write(1'b0);
    chk("R5 empty deny keeps latch", status, 8'h02);

    // R3/R7: grant, busy reads FF for BUSY cycles
    for (int i = 0; i < 4; i++) beats.push_back(AW'(15'h0010 + i));
    arr_write(1'b1);
    chk("R3 busy reads FF", status, 8'hFF);
    chk("R10 ready low busy", pg_ready, 1'b0);
    wait_idle(n);
    chk("R7 busy length", n, BUSY - 1);
    chk("R7 latch cleared after", status, 8'h00);

    // R2/R5 during busy: latch pulses ignored, commit denied
    do_wren();
    beats.push_back(15'h0020); arr_write(1'b1);
    do_wren();
    beats.push_back(15'h0030); arr_write(1'b0);
    wait_idle(n);
    chk("R2 wren ignored busy", status, 8'h00);

    // R8: don't-care data bits, new code visible after busy
    do_wren(); sr_write(8'h67, 1'b1);
    chk("R8 busy during status write", status, 8'hFF);
    wait_idle(n);
    chk("R8 code applied, don't-cares dropped", status, 8'h04);

    // R6: multi-beat writes touching protected bytes
    do_wren();
    for (int i = 0; i < 4; i++) beats.push_back(AW'(15'h7FC0 + i));
    arr_write(1'b0);
    chk("R6 deny keeps latch", status, 8'h06);
    beats.push_back(15'h0100); beats.push_back(15'h0101); beats.push_back(15'h6000);
    arr_write(1'b0);
    beats.push_back(15'h5FFE); beats.push_back(15'h5FFF);
    arr_write(1'b1);
    wait_idle(n);

    // R4: sweep every code over the range edges
    for (int c = 0; c < 8; c++) begin
      do_wren(); sr_write({3'b000, 3'(c), 2'b00}, 1'b1); wait_idle(n);
      chk("R4 code loaded", status, {3'b000, 3'(c), 2'b00});
      for (int k = 0; k < 14; k++) begin
        logic [AW-1:0] a;
        case (k)
          0: a = 15'h0000;  1: a = 15'h003F;  2: a = 15'h0040;  3: a = 15'h007F;
          4: a = 15'h0080;  5: a = 15'h00FF;  6: a = 15'h0100;  7: a = 15'h01FF;
          8: a = 15'h0200;  9: a = 15'h3FFF; 10: a = 15'h4000; 11: a = 15'h5FFF;
          12: a = 15'h6000; default: a = 15'h7FFF;
        endcase
        if (status[1] == 1'b0) do_wren();
        beats.push_back(a);
        arr_write(!prot_model(3'(c), a));
        wait_idle(n);
      end
    end
    if (status[1]) do_wrdi();

    // R8: lock enable set, then pin low blocks status writes
    do_wren(); sr_write(8'h80, 1'b1); wait_idle(n);
    chk("R8 lock enable set", status, 8'h80);
    wp_n = 1'b0;
    do_wren(); sr_write(8'h1C, 1'b0);
    chk("R8 hw protect deny", status, 8'h82);
    wp_n = 1'b1; step();

    // R9: pin dips mid-frame -> abort
    wrsr_open = 1'b1; step(); wrsr_open = 1'b0;
    wp_n = 1'b0; step(); step(); wp_n = 1'b1; step();
    wrsr_data = 8'h00;
    exp_q.push_back(2'b10);
    wrsr_commit = 1'b1; step(); wrsr_commit = 1'b0; step();
    chk("R9 mid-frame abort", status, 8'h82);

    // R9: pin change after grant has no effect
    sr_write(8'h00, 1'b1);
    wp_n = 1'b0; repeat (3) step(); wp_n = 1'b1;
    wait_idle(n);
    chk("R9 granted write completes", status, 8'h00);

    // R10: lock enable clear -> pin ignored
    wp_n = 1'b0;
    do_wren(); sr_write(8'h04, 1'b1); wait_idle(n);
    chk("R10 pin ignored when unlocked", status, 8'h04);
    wp_n = 1'b1;

    repeat (3) step();
    chk("R5 all verdicts seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule